// File: doc/BRIEF.md
# One-Way Multi-Bit Select Memory Mux

This block sits in front of a single memory port and decides which of two requesters may use it. One requester is the integrity checker that reads the memory once after reset. The other is the system bus that serves normal traffic afterwards. A 4-bit select chooses between them. Out of reset the checker owns the port. After the select moves to the bus, it may never move back.

The select uses a redundant multi-bit encoding so that a single flipped bit cannot produce a legal value. Any value other than the two legal codes is treated as an attack or a fault. A move back to the checker after the bus has taken over is treated the same way. Both the live select and a registered copy of it are watched for such a reversion. Any of these events raises a fatal alert. The alert holds until reset, and while it is raised the bus never sees a read-valid.

Requests and addresses follow the live select in the same cycle. Read responses follow the registered select, which is the select of the cycle that issued the read. This matches a memory with one cycle of read latency.

Top module: `onesel_mux`

## Requirements
- R1: With select 4'h9 the checker request and address drive the memory port combinationally. With select 4'h6 the bus request and address drive it.
- R2: During and after reset the alert is low and the registered select holds the checker code 4'h9. In the first cycle after reset, a memory response therefore goes to the checker.
- R3: While the live select is neither 4'h6 nor 4'h9, the memory request and address are zero. Both read-data outputs are zero and both read-valid outputs are low.
- R4: A live select outside {4'h6, 4'h9} raises the alert in the following cycle.
- R5: Memory read data and read-valid go to the requester named by the select of the previous cycle. The other requester sees zero data and no valid.
- R6: Once the live select has been 4'h6, any later live value other than 4'h6 raises the alert in the following cycle. This includes the checker code.
- R7: The registered copy of the select is also checked. Once it has held 4'h6, any later value other than 4'h6 in it raises the alert.
- R8: The alert stays high until reset. While it is high, the bus read-valid is held low.
- R9: A single move from 4'h9 to 4'h6, with no later change, never raises the alert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Multi-bit select: 4'h6 bus, 4'h9 checker |
| chk_req_i | input | 1 | Checker read request |
| chk_addr_i | input | AW | Checker address |
| chk_rdata_o | output | DW | Read data returned to the checker |
| chk_rvalid_o | output | 1 | Read-valid to the checker |
| bus_req_i | input | 1 | Bus read request |
| bus_addr_i | input | AW | Bus address |
| bus_rdata_o | output | DW | Read data returned to the bus |
| bus_rvalid_o | output | 1 | Read-valid to the bus |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | AW | Memory address |
| mem_rdata_i | input | DW | Memory read data |
| mem_rvalid_i | input | 1 | Memory read-valid |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
The embedded properties check the following on every cycle:
- an illegal select leaves the memory port idle and raises the alert one cycle later;
- the alert never drops before reset;
- the bus never sees a valid while the alert is high;
- the two read-valids are never high together;
- a reversion of either the live or the registered select is always followed by the alert;
- a select that has stayed on the checker never alarms.

The bench scenarios show the rest:
- the one-cycle offset between request routing and response routing;
- the reset-time ownership by the checker;
- the full sequence of a clean handover, a reversion and its aftermath;
- zeroed data under many illegal codes.

A fault in the registered copy alone cannot be injected at the ports, so R7 is covered by its property. The bench only checks R7 indirectly, by confirming that the alert persists while that copy follows a reverted live select.

// File: rtl/onesel_pkg.sv
package onesel_pkg;
  typedef logic [3:0] msel_t;
  localparam msel_t SEL_BUS = 4'h6;
  localparam msel_t SEL_CHK = 4'h9;

  typedef struct packed {
    logic bus;
    logic chk;
    logic bad;
  } sel_dec_t;
endpackage

// File: rtl/sel_decode.sv
module sel_decode
  import onesel_pkg::*;
(
  input  msel_t    sel_i,
  output sel_dec_t dec_o
);
  always_comb begin
    dec_o.bus = (sel_i == SEL_BUS);
    dec_o.chk = (sel_i == SEL_CHK);
    dec_o.bad = !(dec_o.bus || dec_o.chk);
  end
endmodule

// File: rtl/sel_guard.sv
module sel_guard
  import onesel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  msel_t sel_i,
  input  logic  live_bus_i,
  input  logic  live_chk_i,
  input  logic  live_bad_i,
  input  logic  regd_bus_i,
  input  logic  regd_bad_i,
  output msel_t sel_q_o,
  output logic  alert_o
);
  msel_t sel_q;
  logic  seen_live_q, seen_live_d, seen_live_en;
  logic  seen_regd_q, seen_regd_d, seen_regd_en;
  logic  alert_q, alert_d, alert_en;
  logic  live_revert, regd_revert, fault;

  always_comb begin
    live_revert  = seen_live_q && !live_bus_i;
    regd_revert  = seen_regd_q && !regd_bus_i;
    fault        = live_bad_i || regd_bad_i || live_revert || regd_revert;
    seen_live_en = live_bus_i && !seen_live_q;
    seen_live_d  = 1'b1;
    seen_regd_en = regd_bus_i && !seen_regd_q;
    seen_regd_d  = 1'b1;
    alert_en     = fault && !alert_q;
    alert_d      = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SEL_CHK;
      seen_live_q <= 1'b0;
      seen_regd_q <= 1'b0;
      alert_q     <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (seen_live_en) seen_live_q <= seen_live_d;
      if (seen_regd_en) seen_regd_q <= seen_regd_d;
      if (alert_en)     alert_q     <= alert_d;
    end
  end

  assign sel_q_o = sel_q;
  assign alert_o = alert_q;

  // R6: live reversion after the handover is always followed by the alert
  a_r6_live_revert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_live_q && !live_bus_i) |=> alert_o);

  // R7: reversion of the registered copy is always followed by the alert
  a_r7_regd_revert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_regd_q && !regd_bus_i) |=> alert_o);

  // R9: staying on the checker before any handover never alarms
  a_r9_quiet_checker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_o && live_chk_i && !seen_live_q) |=> !alert_o);
endmodule

// File: rtl/sel_route.sv
module sel_route #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          live_bus_i,
  input  logic          live_chk_i,
  input  logic          live_bad_i,
  input  logic          regd_bus_i,
  input  logic          regd_chk_i,
  input  logic          alert_i,
  input  logic          chk_req_i,
  input  logic [AW-1:0] chk_addr_i,
  input  logic          bus_req_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] chk_rdata_o,
  output logic          chk_rvalid_o,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_rvalid_o
);
  logic to_bus, to_chk;

  always_comb begin
    if (live_bus_i) begin
      mem_req_o  = bus_req_i;
      mem_addr_o = bus_addr_i;
    end else if (live_chk_i) begin
      mem_req_o  = chk_req_i;
      mem_addr_o = chk_addr_i;
    end else begin
      mem_req_o  = 1'b0;
      mem_addr_o = '0;
    end
    to_bus       = regd_bus_i && !live_bad_i;
    to_chk       = regd_chk_i && !live_bad_i;
    bus_rdata_o  = to_bus ? mem_rdata_i : '0;
    bus_rvalid_o = to_bus && mem_rvalid_i && !alert_i;
    chk_rdata_o  = to_chk ? mem_rdata_i : '0;
    chk_rvalid_o = to_chk && mem_rvalid_i;
  end
endmodule

// File: rtl/onesel_mux.sv
module onesel_mux
  import onesel_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    sel_i,
  input  logic          chk_req_i,
  input  logic [AW-1:0] chk_addr_i,
  output logic [DW-1:0] chk_rdata_o,
  output logic          chk_rvalid_o,
  input  logic          bus_req_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_rvalid_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  output logic          alert_o
);
  localparam int NSRC = 2;

  msel_t    sel_q;
  msel_t    srcs [NSRC];
  sel_dec_t decs [NSRC];

  assign srcs[0] = sel_i;
  assign srcs[1] = sel_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    sel_decode u_dec (.sel_i(srcs[g]), .dec_o(decs[g]));
  end

  sel_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .live_bus_i (decs[0].bus),
    .live_chk_i (decs[0].chk),
    .live_bad_i (decs[0].bad),
    .regd_bus_i (decs[1].bus),
    .regd_bad_i (decs[1].bad),
    .sel_q_o    (sel_q),
    .alert_o    (alert_o)
  );

  sel_route #(.AW(AW), .DW(DW)) u_route (
    .live_bus_i   (decs[0].bus),
    .live_chk_i   (decs[0].chk),
    .live_bad_i   (decs[0].bad),
    .regd_bus_i   (decs[1].bus),
    .regd_chk_i   (decs[1].chk),
    .alert_i      (alert_o),
    .chk_req_i    (chk_req_i),
    .chk_addr_i   (chk_addr_i),
    .bus_req_i    (bus_req_i),
    .bus_addr_i   (bus_addr_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .chk_rdata_o  (chk_rdata_o),
    .chk_rvalid_o (chk_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o)
  );

  // R3: an illegal live select leaves the memory port idle
  a_r3_idle_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decs[0].bad |-> (!mem_req_o && mem_addr_o == '0 && !chk_rvalid_o && !bus_rvalid_o));

  // R4: an illegal live select is followed by the alert
  a_r4_bad_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decs[0].bad |=> alert_o);

  // R8: alert is sticky and blocks bus valids
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);
  a_r8_no_bus_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> !bus_rvalid_o);

  // R5: a response reaches at most one requester
  a_r5_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_rvalid_o && bus_rvalid_o));
endmodule

// File: tb/onesel_mux_test.sv
module onesel_mux_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [3:0]    sel_i;
  logic          chk_req_i, bus_req_i, mem_rvalid_i;
  logic [AW-1:0] chk_addr_i, bus_addr_i;
  logic [DW-1:0] mem_rdata_i;
  logic [DW-1:0] chk_rdata_o, bus_rdata_o;
  logic          chk_rvalid_o, bus_rvalid_o, mem_req_o, alert_o;
  logic [AW-1:0] mem_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] m_selq;
  bit m_seen, m_seenq, m_alert;

  always #(CLK_PERIOD/2) clk = ~clk;

  onesel_mux #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i),
    .chk_req_i(chk_req_i), .chk_addr_i(chk_addr_i),
    .chk_rdata_o(chk_rdata_o), .chk_rvalid_o(chk_rvalid_o),
    .bus_req_i(bus_req_i), .bus_addr_i(bus_addr_i),
    .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
    .alert_o(alert_o)
  );

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit is_legal(logic [3:0] s);
    return (s == 4'h6) || (s == 4'h9);
  endfunction

  task automatic model_reset();
    m_selq = 4'h9; m_seen = 0; m_seenq = 0; m_alert = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; sel_i = 4'h9;
    chk_req_i = 0; bus_req_i = 0; chk_addr_i = '0; bus_addr_i = '0;
    mem_rdata_i = '0; mem_rvalid_i = 0;
    model_reset();
    @(negedge clk);
    check("R2", "alert in reset", {63'd0, alert_o}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // One cycle of stimulus; outputs are checked at mid-cycle, then the model advances.
  task automatic step(logic [3:0] s, string alert_tag);
    logic          cr, br, rv;
    logic [AW-1:0] ca, ba;
    logic [DW-1:0] rd;
    bit lb, lc, lbad, qb, qc, tb_bus, tb_chk, err;
    logic          e_req;
    logic [AW-1:0] e_addr;
    string         rt;
    @(negedge clk);
    cr = 1'($urandom); br = 1'($urandom); rv = 1'($urandom);
    ca = AW'($urandom); ba = AW'($urandom); rd = $urandom;
    sel_i = s; chk_req_i = cr; bus_req_i = br; chk_addr_i = ca; bus_addr_i = ba;
    mem_rdata_i = rd; mem_rvalid_i = rv;
    #1;
    lb = (s == 4'h6); lc = (s == 4'h9); lbad = !is_legal(s);
    qb = (m_selq == 4'h6); qc = (m_selq == 4'h9);
    e_req  = lb ? br : (lc ? cr : 1'b0);
    e_addr = lb ? ba : (lc ? ca : '0);
    rt = lbad ? "R3" : "R1";
    check(rt, "mem_req", {63'd0, mem_req_o}, {63'd0, e_req});
    check(rt, "mem_addr", 64'(mem_addr_o), 64'(e_addr));
    tb_bus = qb && !lbad; tb_chk = qc && !lbad;
    rt = lbad ? "R3" : "R5";
    check(rt, "chk_rdata", 64'(chk_rdata_o), tb_chk ? 64'(rd) : 64'd0);
    check(rt, "chk_rvalid", {63'd0, chk_rvalid_o}, {63'd0, tb_chk && rv});
    check(rt, "bus_rdata", 64'(bus_rdata_o), tb_bus ? 64'(rd) : 64'd0);
    rt = (m_alert && tb_bus && rv) ? "R8" : rt;
    check(rt, "bus_rvalid", {63'd0, bus_rvalid_o}, {63'd0, tb_bus && rv && !m_alert});
    check(alert_tag, "alert", {63'd0, alert_o}, {63'd0, m_alert});
    @(posedge clk);
    err = lbad || !is_legal(m_selq) || (m_seen && !lb) || (m_seenq && !qb);
    m_alert = m_alert || err;
    m_seen  = m_seen || lb;
    m_seenq = m_seenq || qb;
    m_selq  = s;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    // R2: first response after reset goes to the checker
    do_reset();
    step(4'h9, "R2");
    for (int i = 0; i < 20; i++) step(4'h9, "R9");
    // R9: single clean handover; R5 first bus cycle still returns to checker
    for (int i = 0; i < 40; i++) step(4'h6, "R9");
    // R6: reversion to checker
    step(4'h9, "R6");
    step(4'h6, "R6");
    step(4'h6, "R7");
    for (int i = 0; i < 20; i++) step(4'h6, "R8");

    // R3/R4: illegal code before handover
    do_reset();
    step(4'h9, "R2");
    step(4'h3, "R3");
    for (int i = 0; i < 5; i++) step(4'h9, "R4");

    // R4: illegal code after handover, many distinct codes
    for (int k = 0; k < 16; k++) begin
      if (is_legal(4'(k))) continue;
      do_reset();
      step(4'h9, "R2");
      step(4'h6, "R9");
      step(4'(k), "R3");
      step(4'h6, "R4");
      step(4'h6, "R8");
    end

    // Mixed random selects
    for (int r = 0; r < 20; r++) begin
      do_reset();
      for (int i = 0; i < 30; i++) begin
        int pick;
        pick = int'($urandom_range(0, 9));
        if (pick < 4)      step(4'h9, "R4");
        else if (pick < 9) step(4'h6, "R6");
        else               step(4'($urandom), "R4");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule